// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block connects an already-synchronized keyboard front end to a 16-bit memory-mapped bus. Each arriving character comes as a one-cycle strobe with an 8-bit code. The port captures the code in a data register and raises a ready flag in a status register. If software has enabled it, the port also requests an interrupt.

Software can poll the status register or wait for the interrupt. It then reads the data register. That read returns the character, drops the ready flag and opens the port for the next character. While a character is still unread, the port refuses further input. A character that arrives in the same cycle as the clearing read is held for one cycle and then taken, so it is not lost.

Read data depends on the address only while the read strobe is high. The read strobe has a side effect only when it selects the data register.

Top module: `kbd_port`

## Requirements
- R1: After reset, the ready flag, the interrupt enable and the data register are zero: reads of the status register (0xFE00) and the data register (0xFE02) return 0x0000, and `irq` is low.
- R2: When `key_valid` is high while the ready flag is clear and no character is held, the ready flag (status bit 15) reads one from the next cycle. From then on the data register returns the code in bits 7:0, with bits 15:8 zero.
- R3: While the ready flag is set, any arriving character is discarded and the data register keeps its value.
- R4: A bus read at 0xFE02 returns the stored character and clears the ready flag from the next cycle. After that the port accepts new characters.
- R5: A bus write to 0xFE00 loads only the interrupt enable (status bit 14) from write-data bit 14. The ready flag cannot be written, and writes to 0xFE02 have no effect.
- R6: `irq` is high exactly when the ready flag and the interrupt enable are both one.
- R7: A status read returns zero in every bit other than 15 and 14.
- R8: If a character arrives in the same cycle as a data-register read while the ready flag is set, the read returns the old character. The flag then reads zero for one cycle, and on the following cycle the flag is set and the new code is stored.
- R9: Reads at any other address, and reads with `bus_rd` low, return zero. Reading the status register leaves the ready flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_valid | input | 1 | One-cycle strobe: a character code is present |
| key_code | input | 8 | Character code from the keyboard front end |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register, zero otherwise |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: the clearing read of the data register, and the arrival of a new character. The bench provokes this by raising `bus_rd` at 0xFE02 and `key_valid` on the same clock edge while a character is waiting. It then checks three things: the read returns the old code, the status reads zero in the next cycle, and one cycle after that the ready flag and the new code appear.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int unsigned BUS_AW    = 16;
  localparam int unsigned BUS_DW    = 16;
  localparam int unsigned KEY_W     = 8;
  localparam logic [15:0] STAT_ADR  = 16'hFE00;
  localparam logic [15:0] DATA_ADR  = 16'hFE02;
  localparam int unsigned RDY_POS   = 15;
  localparam int unsigned IEN_POS   = 14;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode #(
  parameter int unsigned    AW       = 16,
  parameter logic [AW-1:0]  STAT_A   = '0,
  parameter logic [AW-1:0]  DATA_A   = '0
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          sel_stat,
  output logic          sel_data,
  output logic          data_rd,
  output logic          stat_wr
);
  always_comb begin
    sel_stat = (addr == STAT_A);
    sel_data = (addr == DATA_A);
    data_rd  = rd & sel_data;
    stat_wr  = wr & sel_stat;
  end
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_valid,
  input  logic [CW-1:0] key_code,
  input  logic          data_rd,
  output logic          ready,
  output logic [CW-1:0] data
);
  logic          ready_q, ready_d;
  logic [CW-1:0] data_q, data_d;
  logic          held_q, held_d;
  logic [CW-1:0] held_code_q, held_code_d;
  logic          data_en, held_en;

  always_comb begin
    ready_d     = ready_q;
    data_d      = data_q;
    held_d      = held_q;
    held_code_d = held_code_q;
    data_en     = 1'b0;
    held_en     = 1'b0;
    if (ready_q) begin
      if (data_rd) begin
        ready_d = 1'b0;
        if (key_valid) begin
          held_d      = 1'b1;
          held_code_d = key_code;
          held_en     = 1'b1;
        end
      end
    end else if (held_q) begin
      ready_d = 1'b1;
      data_d  = held_code_q;
      data_en = 1'b1;
      held_d  = 1'b0;
    end else if (key_valid) begin
      ready_d = 1'b1;
      data_d  = key_code;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      data_q      <= '0;
      held_q      <= 1'b0;
      held_code_q <= '0;
    end else begin
      ready_q <= ready_d;
      held_q  <= held_d;
      if (data_en) data_q      <= data_d;
      if (held_en) held_code_q <= held_code_d;
    end
  end

  assign ready = ready_q;
  assign data  = data_q;

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && !held_q && key_valid) |=> (ready_q && data_q == $past(key_code)));

  // R3
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !data_rd) |=> (ready_q && $stable(data_q)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && data_rd) |=> !ready_q);

  // R8
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && data_rd && key_valid) |=> (!ready_q ##1 ready_q));
endmodule

// File: rtl/kbd_ctrl.sv
module kbd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic wr_ien,
  input  logic ready,
  output logic ien,
  output logic irq
);
  logic ien_q, ien_d;

  always_comb begin
    ien_d = ien_q;
    if (stat_wr) ien_d = wr_ien;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= 1'b0;
    else        ien_q <= ien_d;
  end

  assign ien = ien_q;
  assign irq = ready & ien_q;

  // R5
  ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(ien_q));

  // R5
  ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (ien_q == $past(wr_ien)));
endmodule

// File: rtl/kbd_port.sv
module kbd_port
  import kbd_port_pkg::*;
#(
  parameter int unsigned   AW      = BUS_AW,
  parameter int unsigned   DW      = BUS_DW,
  parameter int unsigned   CW      = KEY_W,
  parameter logic [AW-1:0] STAT_A  = STAT_ADR,
  parameter logic [AW-1:0] DATA_A  = DATA_ADR,
  parameter int unsigned   RDY_B   = RDY_POS,
  parameter int unsigned   IEN_B   = IEN_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_valid,
  input  logic [CW-1:0] key_code,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic          rst_sn;
  logic          sel_stat, sel_data, data_rd, stat_wr;
  logic          ready, ien;
  logic [CW-1:0] data;
  logic          wdata_unused;

  assign wdata_unused = ^bus_wdata;

  kbd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sn)
  );

  kbd_addr_decode #(.AW(AW), .STAT_A(STAT_A), .DATA_A(DATA_A)) u_dec (
    .addr     (bus_addr),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .sel_stat (sel_stat),
    .sel_data (sel_data),
    .data_rd  (data_rd),
    .stat_wr  (stat_wr)
  );

  kbd_capture #(.CW(CW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sn),
    .key_valid (key_valid),
    .key_code  (key_code),
    .data_rd   (data_rd),
    .ready     (ready),
    .data      (data)
  );

  kbd_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sn),
    .stat_wr (stat_wr),
    .wr_ien  (bus_wdata[IEN_B]),
    .ready   (ready),
    .ien     (ien),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_stat) begin
        bus_rdata[RDY_B] = ready;
        bus_rdata[IEN_B] = ien;
      end else if (sel_data) begin
        bus_rdata[CW-1:0] = data;
      end
    end
  end

  // R9
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && sel_stat && ready) |=> ready);

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (stat_wr && bus_wdata[IEN_B] && ready && !data_rd) |=> irq);
endmodule

// File: tb/kbd_port_tb_top.sv
module kbd_port_tb_top;
  localparam logic [15:0] STAT = 16'hFE00;
  localparam logic [15:0] DATA = 16'hFE02;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_valid;
  logic [7:0]  key_code;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kbd_port dut_i (
    .clk (clk), .rst_n (rst_n), .key_valid (key_valid), .key_code (key_code),
    .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 16'h0000;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 16'h0000; bus_wdata = '0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk);
    key_valid = 1'b1; key_code = c;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(STAT, d); check("R1 status", d, 16'h0000);
    rd(DATA, d); check("R1 data", d, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_receive();
    logic [15:0] d;
    key(8'h41);
    rd(STAT, d); check("R2 ready set", d, 16'h8000);
    rd(DATA, d); check("R2 R4 data", d, 16'h0041);
    rd(STAT, d); check("R4 ready cleared", d, 16'h0000);
  endtask

  task automatic t_lockout();
    logic [15:0] d;
    key(8'h61);
    key(8'h62);
    rd(DATA, d); check("R3 discard", d, 16'h0061);
    rd(STAT, d); check("R4 cleared", d, 16'h0000);
    key(8'hE3);
    rd(DATA, d); check("R4 re-enabled", d, 16'h00E3);
  endtask

  task automatic t_status_write();
    logic [15:0] d;
    wr(STAT, 16'hFFFF);
    rd(STAT, d); check("R5 R7 only ien", d, 16'h4000);
    check("R6 irq low w/o ready", {15'd0, irq}, 16'h0000);
    key(8'h10);
    #1 check("R6 irq high", {15'd0, irq}, 16'h0001);
    rd(STAT, d); check("R7 status", d, 16'hC000);
    wr(STAT, 16'h0000);
    #1 check("R6 irq low w/o ien", {15'd0, irq}, 16'h0000);
    rd(STAT, d); check("R5 flag not writable", d, 16'h8000);
    wr(STAT, 16'h4000);
    wr(DATA, 16'h00FF);
    rd(DATA, d); check("R5 data write ignored", d, 16'h0010);
    #1 check("R6 irq drops after read", {15'd0, irq}, 16'h0000);
    wr(STAT, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    key(8'h31);
    @(negedge clk);
    bus_addr = DATA; bus_rd = 1'b1; key_valid = 1'b1; key_code = 8'h32;
    #2 check("R8 old char", bus_rdata, 16'h0031);
    @(negedge clk);
    key_valid = 1'b0; bus_addr = STAT;
    #2 check("R8 flag low one cycle", bus_rdata, 16'h0000);
    @(negedge clk);
    #2 check("R8 flag set next", bus_rdata, 16'h8000);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 16'h0000;
    rd(DATA, d); check("R8 new char kept", d, 16'h0032);
  endtask

  task automatic t_other();
    logic [15:0] d;
    key(8'h55);
    rd(16'hFE04, d); check("R9 other addr", d, 16'h0000);
    rd(STAT, d); check("R9 status read 1", d, 16'h8000);
    rd(STAT, d); check("R9 status read keeps flag", d, 16'h8000);
    @(negedge clk);
    bus_addr = DATA;
    #2 check("R9 no strobe zero", bus_rdata, 16'h0000);
    rd(DATA, d); check("R9 data after peeks", d, 16'h0055);
  endtask

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; key_code = '0;
    bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_receive();
    t_lockout();
    t_status_write();
    t_collision();
    t_other();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule